// File: doc/BRIEF.md
# MSI Message Ring-Buffer Controller

This block takes in message-signalled interrupt writes, one 32-bit data word at a time. It logs each one as a 16-byte record in a circular buffer that lives in system memory. For each accepted message it builds a memory write request. The address of that request is a programmable 64-bit base plus the block's own producer offset. Once the memory port has taken the record, the producer offset moves forward by one record and wraps at the configured buffer size. While the consumer offset, which software owns, differs from the producer offset, the block holds a single level interrupt toward the host.

Software configures the block through a small register port with word offsets. It picks one of four buffer sizes, from 32 KB up to 256 KB. It drains records by moving the consumer offset forward. A buffer that fills up can be handled in one of two ways. The block can push back on the inbound port, or it can throw the message away and count it. An optional sticky flag marks that the buffer has reached full.

Top module: `msi_ring_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` and `mem_valid` are low, and both offsets read zero.
- R2: Register word offsets are: control 0, status 1, dropped count 2, base high 3, base low 4, consumer offset 5, producer offset 6. Any other offset reads zero. Control bit 0 is enable, bit 1 is full-flag enable, bit 3 is interrupt enable, bit 4 is stop-on-full, and bits 9:8 are the size field. All other control bits read zero.
- R3: An accepted message produces a request at address {base high, base low} + producer offset. Data bits 15:0 carry the low 16 bits of the message, with byte 0 of the record in data bits 7:0. Data bits 127:16 are zero.
- R4: The producer offset advances by 16 only in the cycle that `mem_valid` and `mem_ready` are both high. While a request is outstanding, `msg_ready` is low and the request's address and data stay constant.
- R5: Offsets wrap modulo 2^(15+n) bytes, where n is the size field (0 to 3). Offsets read back with the bits at and above that size cleared.
- R6: A write to the consumer offset stores the value with bits 3:0 cleared. A write to the producer offset has no effect.
- R7: `irq` is high exactly when interrupt enable is set and the consumer offset differs from the producer offset.
- R8: The buffer is full when the producer offset plus 16, after wrapping, equals the consumer offset. Status bit 0 is set while the buffer is full and full-flag enable is set. The bit holds its value until software writes 1 to status bit 0 while the set condition is absent.
- R9: With the block enabled, the buffer full and stop-on-full set, `msg_ready` is low and the dropped count does not change.
- R10: With the block enabled, the buffer full and stop-on-full clear, an offered message is accepted and discarded, and the dropped count goes up by one. The count saturates at all ones.
- R11: With enable clear, inbound messages are accepted and discarded: no request is issued, no offset changes, and nothing is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| msg_valid | input | 1 | Inbound message present |
| msg_data | input | 32 | Inbound message data word |
| msg_ready | output | 1 | Block takes the message this cycle |
| mem_valid | output | 1 | Memory write request pending |
| mem_addr | output | 64 | Record byte address |
| mem_data | output | 128 | Record contents, byte 0 in bits 7:0 |
| mem_ready | input | 1 | Memory port accepts the request |
| irq | output | 1 | Cascaded interrupt level |

## Verification
Single messages with a ready memory port check the address arithmetic and the zero padding. Messages held by a stalled `mem_ready` show whether the producer offset moves on acceptance of the message or on completion of the write. A run of 2047 back-to-back records through the smallest buffer wraps the offset and ends exactly at full. That boundary is then hit with stop-on-full clear, which shows dropping and counting, and with it set, which shows back-pressure. A long held message on a full buffer reaches counter saturation. Disabled and interrupt-masked runs show that those controls cut logging and the interrupt independently.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;

   // register word offsets
   localparam int RA_CTRL    = 0;
   localparam int RA_STATUS  = 1;
   localparam int RA_DROPS   = 2;
   localparam int RA_BASE_HI = 3;
   localparam int RA_BASE_LO = 4;
   localparam int RA_CONS    = 5;
   localparam int RA_PROD    = 6;

   // control bit positions
   localparam int CB_EN      = 0;
   localparam int CB_FULL_EN = 1;
   localparam int CB_IRQ_EN  = 3;
   localparam int CB_STOP    = 4;
   localparam int CB_SIZE_LO = 8;

   localparam int REG_DW = 32;

   typedef struct packed {
      logic stop;
      logic irq_en;
      logic full_en;
      logic en;
   } ring_flags_t;

endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
   import msi_ring_pkg::*;
#(
   parameter int REG_AW      = 3,
   parameter int OFF_W       = 18,
   parameter int SIZE_W      = 2,
   parameter int MIN_SHIFT   = 15,
   parameter int ENTRY_BYTES = 16,
   parameter int ADDR_W      = 64,
   parameter int DROP_W      = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [REG_DW-1:0]   reg_wdata,
   output logic [REG_DW-1:0]   reg_rdata,
   input  logic [OFF_W-1:0]    prod_off,
   input  logic                full_set,
   input  logic [DROP_W-1:0]   drop_cnt,
   output ring_flags_t         flags,
   output logic [SIZE_W-1:0]   size_sel,
   output logic [OFF_W-1:0]    off_mask,
   output logic [ADDR_W-1:0]   base_addr,
   output logic [OFF_W-1:0]    cons_off
);

   localparam int ALIGN = $clog2(ENTRY_BYTES);

   ring_flags_t         flags_q;
   logic [SIZE_W-1:0]   size_q;
   logic [REG_DW-1:0]   base_hi_q;
   logic [REG_DW-1:0]   base_lo_q;
   logic [OFF_W-1:0]    cons_q;
   logic                full_q;
   logic [REG_DW-1:0]   ctrl_view;

   function automatic logic hit(input logic [REG_AW-1:0] a, input int idx);
      return a == REG_AW'(idx);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q   <= '0;
         size_q    <= '0;
         base_hi_q <= '0;
         base_lo_q <= '0;
         cons_q    <= '0;
      end else if (reg_wr) begin
         if (hit(reg_addr, RA_CTRL)) begin
            flags_q.en      <= reg_wdata[CB_EN];
            flags_q.full_en <= reg_wdata[CB_FULL_EN];
            flags_q.irq_en  <= reg_wdata[CB_IRQ_EN];
            flags_q.stop    <= reg_wdata[CB_STOP];
            size_q          <= reg_wdata[CB_SIZE_LO +: SIZE_W];
         end
         if (hit(reg_addr, RA_BASE_HI)) base_hi_q <= reg_wdata;
         if (hit(reg_addr, RA_BASE_LO)) base_lo_q <= reg_wdata;
         if (hit(reg_addr, RA_CONS)) begin
            cons_q <= {reg_wdata[OFF_W-1:ALIGN], {ALIGN{1'b0}}};
         end
      end
   end

   // sticky full indication, write-one-to-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
      end else if (full_set) begin
         full_q <= 1'b1;
      end else if (reg_wr && hit(reg_addr, RA_STATUS) && reg_wdata[0]) begin
         full_q <= 1'b0;
      end
   end

   always_comb begin
      off_mask = OFF_W'((64'd1 << (MIN_SHIFT + int'(size_q))) - 64'd1);
      off_mask[ALIGN-1:0] = '0;
   end

   always_comb begin
      ctrl_view = '0;
      ctrl_view[CB_EN]      = flags_q.en;
      ctrl_view[CB_FULL_EN] = flags_q.full_en;
      ctrl_view[CB_IRQ_EN]  = flags_q.irq_en;
      ctrl_view[CB_STOP]    = flags_q.stop;
      ctrl_view[CB_SIZE_LO +: SIZE_W] = size_q;
   end

   assign cons_off  = cons_q & off_mask;
   assign flags     = flags_q;
   assign size_sel  = size_q;
   assign base_addr = ADDR_W'({base_hi_q, base_lo_q});

   always_comb begin
      reg_rdata = '0;
      case (int'(reg_addr))
         RA_CTRL:    reg_rdata = ctrl_view;
         RA_STATUS:  reg_rdata = REG_DW'(full_q);
         RA_DROPS:   reg_rdata = REG_DW'(drop_cnt);
         RA_BASE_HI: reg_rdata = base_hi_q;
         RA_BASE_LO: reg_rdata = base_lo_q;
         RA_CONS:    reg_rdata = REG_DW'(cons_off);
         RA_PROD:    reg_rdata = REG_DW'(prod_off);
         default:    reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/msi_ring_ptr.sv
module msi_ring_ptr
   import msi_ring_pkg::*;
#(
   parameter int OFF_W       = 18,
   parameter int ENTRY_BYTES = 16,
   parameter int DROP_W      = 16,
   parameter bit DROP_SAT    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  ring_flags_t        flags,
   input  logic [OFF_W-1:0]   off_mask,
   input  logic [OFF_W-1:0]   cons_off,
   input  logic               msg_valid,
   input  logic               busy,
   input  logic               wr_done,
   output logic               msg_ready,
   output logic               load,
   output logic [OFF_W-1:0]   prod_off,
   output logic               full_set,
   output logic [DROP_W-1:0]  drop_cnt,
   output logic               irq
);

   logic [OFF_W-1:0] prod_q;
   logic [OFF_W-1:0] prod_nxt;
   logic             full;
   logic             take;
   logic             drop;

   assign prod_off = prod_q & off_mask;
   assign prod_nxt = (prod_off + OFF_W'(ENTRY_BYTES)) & off_mask;
   assign full     = (prod_nxt == cons_off);

   assign msg_ready = !flags.en || (!busy && !(full && flags.stop));
   assign take      = msg_valid && msg_ready && flags.en;
   assign load      = take && !full;
   assign drop      = take && full;
   assign full_set  = full && flags.full_en;
   assign irq       = flags.irq_en && (prod_off != cons_off);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_q <= '0;
      end else if (wr_done) begin
         prod_q <= prod_nxt;
      end
   end

   logic [DROP_W-1:0] drop_q;

   generate
      if (DROP_SAT) begin : g_drop_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               drop_q <= '0;
            end else if (drop && (drop_q != {DROP_W{1'b1}})) begin
               drop_q <= drop_q + 1'b1;
            end
         end
      end else begin : g_drop_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               drop_q <= '0;
            end else if (drop) begin
               drop_q <= drop_q + 1'b1;
            end
         end
      end
   endgenerate

   assign drop_cnt = drop_q;

endmodule

// File: rtl/msi_ring_wr.sv
module msi_ring_wr #(
   parameter int OFF_W   = 18,
   parameter int ADDR_W  = 64,
   parameter int ENTRY_W = 128,
   parameter int MSG_W   = 32,
   parameter int IRQ_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [ADDR_W-1:0]  base_addr,
   input  logic [OFF_W-1:0]   prod_off,
   input  logic [MSG_W-1:0]   msg_data,
   input  logic               mem_ready,
   output logic               mem_valid,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [ENTRY_W-1:0] mem_data,
   output logic               busy,
   output logic               wr_done
);

   logic               valid_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [ENTRY_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
         data_q  <= '0;
      end else if (load) begin
         valid_q <= 1'b1;
         addr_q  <= base_addr + ADDR_W'(prod_off);
         data_q  <= ENTRY_W'(msg_data[IRQ_W-1:0]);
      end else if (valid_q && mem_ready) begin
         valid_q <= 1'b0;
      end
   end

   assign mem_valid = valid_q;
   assign mem_addr  = addr_q;
   assign mem_data  = data_q;
   assign busy      = valid_q;
   assign wr_done   = valid_q && mem_ready;

endmodule

// File: rtl/msi_ring_ctrl.sv
module msi_ring_ctrl
   import msi_ring_pkg::*;
#(
   parameter int REG_AW      = 3,
   parameter int ADDR_W      = 64,
   parameter int MSG_W       = 32,
   parameter int IRQ_W       = 16,
   parameter int ENTRY_BYTES = 16,
   parameter int MIN_SHIFT   = 15,
   parameter int SIZE_W      = 2,
   parameter int DROP_W      = 16,
   parameter bit DROP_SAT    = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_wr,
   input  logic [REG_AW-1:0]         reg_addr,
   input  logic [31:0]               reg_wdata,
   output logic [31:0]               reg_rdata,
   input  logic                      msg_valid,
   input  logic [MSG_W-1:0]          msg_data,
   output logic                      msg_ready,
   output logic                      mem_valid,
   output logic [ADDR_W-1:0]         mem_addr,
   output logic [ENTRY_BYTES*8-1:0]  mem_data,
   input  logic                      mem_ready,
   output logic                      irq
);

   localparam int ENTRY_W = ENTRY_BYTES * 8;
   localparam int OFF_W   = MIN_SHIFT + (1 << SIZE_W) - 1;

   generate
      if (ENTRY_BYTES < 4 || (ENTRY_BYTES & (ENTRY_BYTES - 1)) != 0) begin : g_bad_entry
         $error("ENTRY_BYTES must be a power of two of at least 4");
      end
      if (IRQ_W > MSG_W || IRQ_W > ENTRY_W) begin : g_bad_irq
         $error("IRQ_W must fit both the message and the record");
      end
      if (ADDR_W > 64 || ADDR_W < OFF_W) begin : g_bad_addr
         $error("ADDR_W must lie between OFF_W and 64");
      end
      if (OFF_W > REG_DW || DROP_W > REG_DW) begin : g_bad_reg
         $error("offset and counter must fit one register");
      end
      if (CB_SIZE_LO + SIZE_W > REG_DW || REG_AW < 3) begin : g_bad_map
         $error("register map does not fit");
      end
   endgenerate

   ring_flags_t         flags;
   logic [SIZE_W-1:0]   size_sel;
   logic [OFF_W-1:0]    off_mask;
   logic [ADDR_W-1:0]   base_addr;
   logic [OFF_W-1:0]    cons_off;
   logic [OFF_W-1:0]    prod_off;
   logic                full_set;
   logic [DROP_W-1:0]   drop_cnt;
   logic                load;
   logic                busy;
   logic                wr_done;

   msi_ring_regs #(
      .REG_AW(REG_AW), .OFF_W(OFF_W), .SIZE_W(SIZE_W), .MIN_SHIFT(MIN_SHIFT),
      .ENTRY_BYTES(ENTRY_BYTES), .ADDR_W(ADDR_W), .DROP_W(DROP_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .prod_off(prod_off), .full_set(full_set), .drop_cnt(drop_cnt),
      .flags(flags), .size_sel(size_sel), .off_mask(off_mask),
      .base_addr(base_addr), .cons_off(cons_off)
   );

   msi_ring_ptr #(
      .OFF_W(OFF_W), .ENTRY_BYTES(ENTRY_BYTES), .DROP_W(DROP_W), .DROP_SAT(DROP_SAT)
   ) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .flags(flags), .off_mask(off_mask), .cons_off(cons_off),
      .msg_valid(msg_valid), .busy(busy), .wr_done(wr_done),
      .msg_ready(msg_ready), .load(load), .prod_off(prod_off),
      .full_set(full_set), .drop_cnt(drop_cnt), .irq(irq)
   );

   msi_ring_wr #(
      .OFF_W(OFF_W), .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .MSG_W(MSG_W), .IRQ_W(IRQ_W)
   ) u_wr (
      .clk(clk), .rst_n(rst_n),
      .load(load), .base_addr(base_addr), .prod_off(prod_off), .msg_data(msg_data),
      .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
      .mem_data(mem_data), .busy(busy), .wr_done(wr_done)
   );

endmodule

// File: rtl/msi_ring_chk.sv
module msi_ring_chk
   import msi_ring_pkg::*;
#(
   parameter int OFF_W   = 18,
   parameter int ADDR_W  = 64,
   parameter int ENTRY_W = 128,
   parameter int IRQ_W   = 16,
   parameter int SIZE_W  = 2,
   parameter int DROP_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               msg_ready,
   input logic               mem_valid,
   input logic               mem_ready,
   input logic [ADDR_W-1:0]  mem_addr,
   input logic [ENTRY_W-1:0] mem_data,
   input logic               irq,
   input ring_flags_t        flags,
   input logic [SIZE_W-1:0]  size_sel,
   input logic [OFF_W-1:0]   prod_off,
   input logic [DROP_W-1:0]  drop_cnt
);

   p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

   p_no_take_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && flags.en) |-> !msg_ready);

   p_prod_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_valid && mem_ready) ##1 $stable(size_sel) |-> $stable(prod_off));

   p_zero_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_data[ENTRY_W-1:IRQ_W] == '0));

   p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !flags.irq_en |-> !irq);

   p_drop_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (drop_cnt == $past(drop_cnt)) || (drop_cnt == DROP_W'($past(drop_cnt) + 1'b1)));

   p_off_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags.en && !mem_valid) |=> !mem_valid);

endmodule

bind msi_ring_ctrl msi_ring_chk #(
   .OFF_W(OFF_W), .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .IRQ_W(IRQ_W),
   .SIZE_W(SIZE_W), .DROP_W(DROP_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .msg_ready(msg_ready), .mem_valid(mem_valid),
   .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq),
   .flags(flags), .size_sel(size_sel), .prod_off(prod_off), .drop_cnt(drop_cnt)
);

// File: tb/msi_ring_ctrl_tb.sv
`timescale 1ns/100ps
module msi_ring_ctrl_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr = 1'b0;
   logic [2:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         msg_valid = 1'b0;
   logic [31:0]  msg_data = '0;
   logic         msg_ready;
   logic         mem_valid;
   logic [63:0]  mem_addr;
   logic [127:0] mem_data;
   logic         mem_ready = 1'b1;
   logic         irq;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   msi_ring_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
      .msg_data(msg_data), .msg_ready(msg_ready), .mem_valid(mem_valid),
      .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready), .irq(irq)
   );

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [31:0]  m_ctrl, m_hi, m_lo, m_rd, m_wr, m_drop;
   logic         m_flag, m_pend;
   logic [63:0]  m_paddr;
   logic [127:0] m_pdata;

   function automatic logic [31:0] m_size();
      return 32'd1 << (15 + m_ctrl[9:8]);
   endfunction
   function automatic logic [31:0] m_weff();
      return m_wr % m_size();
   endfunction
   function automatic logic [31:0] m_reff();
      return m_rd % m_size();
   endfunction
   function automatic logic m_full();
      return ((m_weff() + 32'd16) % m_size()) == m_reff();
   endfunction
   function automatic logic m_ready();
      return !m_ctrl[0] || (!m_pend && !(m_full() && m_ctrl[4]));
   endfunction
   function automatic logic [31:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return m_ctrl;
         3'd1: return {31'd0, m_flag};
         3'd2: return m_drop;
         3'd3: return m_hi;
         3'd4: return m_lo;
         3'd5: return m_reff();
         3'd6: return m_weff();
         default: return 32'd0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl = 0; m_hi = 0; m_lo = 0; m_rd = 0; m_wr = 0; m_drop = 0;
         m_flag = 0; m_pend = 0; m_paddr = 0; m_pdata = 0;
      end else begin
         logic full_now, rdy_now, done_now;
         full_now = m_full();
         rdy_now  = m_ready();
         done_now = m_pend && mem_ready;
         if (full_now && m_ctrl[1]) m_flag = 1;
         else if (reg_wr && reg_addr == 3'd1 && reg_wdata[0]) m_flag = 0;
         if (msg_valid && rdy_now && m_ctrl[0]) begin
            if (!full_now) begin
               m_pend  = 1;
               m_paddr = {m_hi, m_lo} + 64'(m_weff());
               m_pdata = 128'(msg_data[15:0]);
            end else if (m_drop != 32'hFFFF) begin
               m_drop = m_drop + 1;
            end
         end
         if (done_now) begin
            m_pend = 0;
            m_wr   = (m_weff() + 32'd16) % m_size();
         end
         if (reg_wr) begin
            case (reg_addr)
               3'd0: m_ctrl = reg_wdata & 32'h31B;
               3'd3: m_hi   = reg_wdata;
               3'd4: m_lo   = reg_wdata;
               3'd5: m_rd   = reg_wdata & 32'h3FFF0;
               default: ;
            endcase
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R4 mem_valid vs model", mem_valid, m_pend);
         if (m_pend) begin
            chk("R3 mem_addr vs model", mem_addr, m_paddr);
            chk("R3 mem_data vs model", mem_data, m_pdata);
         end
         chk("R7 irq vs model", irq, m_ctrl[3] && (m_weff() != m_reff()));
         chk("R9 msg_ready vs model", msg_ready, m_ready());
         chk("R2 reg_rdata vs model", reg_rdata, m_read(reg_addr));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wreg(input int a, input logic [31:0] d);
      @(negedge clk); #1;
      reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
      @(negedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rreg(input string tag, input int a, input logic [31:0] exp);
      @(negedge clk); #1;
      reg_addr = 3'(a);
      @(negedge clk);
      chk(tag, reg_rdata, exp);
      #1;
   endtask

   task automatic send(input logic [31:0] d);
      @(negedge clk); #1;
      msg_valid = 1'b1; msg_data = d;
      while (!msg_ready) begin
         @(negedge clk); #1;
      end
      @(negedge clk); #1;
      msg_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      tick(1);

      // R1: reset state
      for (int a = 0; a < 8; a++) rreg("R1 register after reset", a, 32'd0);
      chk("R1 irq after reset", irq, 1'b0);
      chk("R1 mem_valid after reset", mem_valid, 1'b0);

      // R2: control bit layout
      wreg(0, 32'hFFFF_FFFF);
      rreg("R2 control implemented bits", 0, 32'h0000_031B);
      wreg(0, 32'h9);
      wreg(3, 32'h1);
      wreg(4, 32'h8000_0000);
      rreg("R2 base high", 3, 32'h1);
      rreg("R2 base low", 4, 32'h8000_0000);
      rreg("R2 unmapped offset", 7, 32'd0);

      // R6: producer offset not writable
      wreg(6, 32'h120);
      rreg("R6 producer write ignored", 6, 32'd0);

      // R3/R4/R7: one record
      send(32'hABCD_1234);
      tick(3);
      rreg("R4 producer after one record", 6, 32'h10);
      chk("R7 irq with pending record", irq, 1'b1);
      wreg(5, 32'h10);
      tick(1);
      chk("R7 irq after consumer catches up", irq, 1'b0);

      // R4: stalled memory port
      mem_ready = 1'b0;
      send(32'h0000_0055);
      tick(5);
      chk("R4 request held while stalled", mem_valid, 1'b1);
      chk("R4 no new message while busy", msg_ready, 1'b0);
      rreg("R4 producer still during stall", 6, 32'h10);
      mem_ready = 1'b1;
      tick(2);
      rreg("R4 producer after handshake", 6, 32'h20);

      // R6/R5: consumer alignment and size masking
      wreg(5, 32'h0001_A345);
      rreg("R6 consumer aligned and masked 32K", 5, 32'h2340);
      wreg(0, 32'h309);
      rreg("R5 consumer under 256K size", 5, 32'h1A340);
      wreg(0, 32'h9);
      wreg(5, 32'h20);

      // R5/R8/R10: fill to full with drop mode
      wreg(0, 32'hB);
      for (int i = 0; i < 2047; i++) send(32'h0001_0000 + 32'(i));
      tick(3);
      rreg("R5 producer wrapped to 0x10", 6, 32'h10);
      rreg("R8 sticky full set", 1, 32'h1);
      for (int i = 0; i < 3; i++) send(32'hDEAD_0000 + 32'(i));
      tick(2);
      rreg("R10 three dropped", 2, 32'd3);
      rreg("R10 producer unchanged on drop", 6, 32'h10);
      chk("R10 nothing issued on drop", mem_valid, 1'b0);

      // R8: clear once no longer full
      wreg(5, 32'h40);
      wreg(1, 32'h1);
      rreg("R8 full flag cleared", 1, 32'h0);

      // R9: stop-on-full back-pressure
      wreg(0, 32'h1B);
      send(32'h77);
      send(32'h78);
      tick(3);
      rreg("R9 producer at full point", 6, 32'h30);
      @(negedge clk); #1;
      msg_valid = 1'b1; msg_data = 32'h79;
      tick(6);
      chk("R9 back-pressure when full", msg_ready, 1'b0);
      msg_valid = 1'b0;
      rreg("R9 no drop counted", 2, 32'd3);

      // R7: interrupt masked
      wreg(5, 32'h30);
      wreg(0, 32'h1);
      send(32'h80);
      tick(3);
      rreg("R7 producer moved", 6, 32'h40);
      chk("R7 irq masked with backlog", irq, 1'b0);

      // R11: disabled block discards
      wreg(0, 32'h0);
      send(32'h81);
      tick(3);
      rreg("R11 producer unchanged when disabled", 6, 32'h40);
      rreg("R11 no drop when disabled", 2, 32'd3);
      chk("R11 no request when disabled", mem_valid, 1'b0);

      // R10: saturation of the drop count
      wreg(5, 32'h50);
      wreg(0, 32'h3);
      @(negedge clk); #1;
      msg_valid = 1'b1; msg_data = 32'h99;
      tick(65540);
      msg_valid = 1'b0;
      rreg("R10 drop count saturates", 2, 32'h0000_FFFF);

      tick(4);
      finish_run();
   end

endmodule